// File: doc/BRIEF.md
# Byte-time analog output window timer

This block sets the timing of the interval during which an internal analog node is switched onto a shared output pin. Its unit of time is the byte time, which is eight learned bit periods. The bit period arrives as a count of clock cycles from the serial port's baud learning. A start strobe opens a sequence with three parts: a one-byte lead-in, an analog window whose length grows exponentially with a 4-bit duration code, and a one-byte lead-out. For the whole sequence the block raises a hold-off signal that keeps the serial port tri-stated and deaf. The analog-connect enable is high only during the window.

The block latches the analog node select and passes it through to the multiplexer. It captures the select, the duration code and the bit period on the start strobe, so later changes on those inputs do not disturb a running sequence. The highest duration code selects continuous mode. In that mode the analog enable stays on indefinitely and the hold-off covers a fixed, long number of byte times. After the hold-off ends, any command the serial port accepts re-arms a full hold-off. Continuous mode ends only on reset or on a re-initialize strobe.

All pins are plain control and status pins: single-cycle strobes in, levels out. There is no data stream and no back-pressure.

Top module: `aow_window_timer`

## Requirements
- R1: During and after reset, with no strobe yet, ana_en_o and holdoff_o are 0 and sel_o is 0.
- R2: A start_i sampled while holdoff_o and ana_en_o are both low raises holdoff_o in the next cycle. ana_en_o rises exactly one byte time later, where a byte time is 8*P clock cycles and P is the bit period sampled with the strobe.
- R3: For duration codes 0 to 14, ana_en_o stays high for exactly (2^code + 1) byte times. Code 0 gives 2 byte times and code 14 gives 16,385.
- R4: When ana_en_o drops at the end of a timed window, holdoff_o stays high for exactly one more byte time and then drops. The whole sequence spans (2^code + 3) byte times.
- R5: start_i and cmd_i are ignored while holdoff_o is high: the outputs and their timing are unchanged. cmd_i is also ignored while the block is idle.
- R6: Duration code 15 (all ones) selects continuous mode. ana_en_o rises one byte time after the strobe and then stays high. holdoff_o covers CONT_HOLD_BYTES byte times from the strobe (default 32,769).
- R7: In continuous mode with holdoff_o low, a start_i or cmd_i strobe raises holdoff_o again for a full CONT_HOLD_BYTES byte times from that strobe. The latched select and bit period do not change.
- R8: A reinit_i strobe forces ana_en_o and holdoff_o low in the next cycle from any state, continuous mode included. It takes priority over a start_i in the same cycle, which is then ignored.
- R9: sel_o shows the sel_i value sampled with the accepted start_i of the current or last sequence. It does not change while holdoff_o is high.
- R10: A bit period of 0 is treated as 1. Changes on bit_period_i and code_i after the start strobe do not affect a running sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Analog-output command strobe |
| cmd_i | input | 1 | Any-other-command strobe (re-arms continuous hold-off) |
| reinit_i | input | 1 | Re-initialize strobe, returns the block to idle |
| code_i | input | 4 | Duration code, sampled with start_i |
| sel_i | input | 4 | Analog node select, sampled with start_i |
| bit_period_i | input | 8 | Learned bit period in clock cycles, sampled with start_i |
| ana_en_o | output | 1 | Analog-connect enable |
| sel_o | output | 4 | Latched analog node select |
| holdoff_o | output | 1 | Serial port hold-off (tri-state and ignore input) |

## Verification
Two pairs of events can land in the same cycle. A re-initialize can arrive together with a start strobe, and the R8 priority rule says the start is dropped. A command strobe can also be held across the exact cycle in which the continuous hold-off expires, and R5 and R7 require it to count only once holdoff_o is low. The bench provokes both by holding strobes across these boundaries. A behavioural model counts cycles and byte times and is compared with ana_en_o, holdoff_o and sel_o on every clock, so a strobe taken one cycle early or late shows up as a mismatch.

// File: rtl/aow_pkg.sv
package aow_pkg;
  typedef enum logic [2:0] {
    PH_IDLE    = 3'd0,
    PH_LEAD    = 3'd1,
    PH_WIN     = 3'd2,
    PH_TAIL    = 3'd3,
    PH_CHOLD   = 3'd4,
    PH_CLISTEN = 3'd5
  } aow_phase_e;
endpackage

// File: rtl/aow_byte_tick.sv
module aow_byte_tick #(
  parameter int BIT_W         = 8,
  parameter int BITS_PER_BYTE = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             run,
  input  logic [BIT_W-1:0] bit_len,
  output logic             tick
);
  localparam int IDX_W = (BITS_PER_BYTE > 1) ? $clog2(BITS_PER_BYTE) : 1;
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(BITS_PER_BYTE - 1);

  logic [BIT_W-1:0] cyc_q;
  logic [IDX_W-1:0] idx_q;
  logic             bit_end;

  assign bit_end = (cyc_q == bit_len - BIT_W'(1));
  assign tick    = run && bit_end && (idx_q == IDX_LAST);

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      cyc_q <= '0;
      idx_q <= '0;
    end else if (run) begin
      if (bit_end) begin
        cyc_q <= '0;
        if (idx_q == IDX_LAST) idx_q <= '0;
        else                   idx_q <= idx_q + IDX_W'(1);
      end else begin
        cyc_q <= cyc_q + BIT_W'(1);
      end
    end
  end
endmodule

// File: rtl/aow_len_decode.sv
module aow_len_decode #(
  parameter int CODE_W = 4,
  parameter int CNT_W  = 16
) (
  input  logic [CODE_W-1:0] code,
  output logic [CNT_W-1:0]  win_extra,
  output logic              is_cont
);
  assign is_cont   = &code;
  assign win_extra = CNT_W'(1) << code;
endmodule

// File: rtl/aow_window_timer.sv
module aow_window_timer #(
  parameter int BIT_W           = 8,
  parameter int BITS_PER_BYTE   = 8,
  parameter int CODE_W          = 4,
  parameter int SEL_W           = 4,
  parameter int CNT_W           = 16,
  parameter int CONT_HOLD_BYTES = 32769
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              cmd_i,
  input  logic              reinit_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic [SEL_W-1:0]  sel_i,
  input  logic [BIT_W-1:0]  bit_period_i,
  output logic              ana_en_o,
  output logic [SEL_W-1:0]  sel_o,
  output logic              holdoff_o
);
  import aow_pkg::*;

  localparam logic [CNT_W-1:0] CONT_FIRST = CNT_W'(CONT_HOLD_BYTES - 2);
  localparam logic [CNT_W-1:0] CONT_FULL  = CNT_W'(CONT_HOLD_BYTES - 1);

  aow_phase_e        phase_q;
  logic [CNT_W-1:0]  left_q;
  logic [CODE_W-1:0] code_q;
  logic [SEL_W-1:0]  sel_q;
  logic [BIT_W-1:0]  bp_q;

  logic             accept, restart, run, tick, is_cont;
  logic [CNT_W-1:0] win_extra;

  assign accept  = (phase_q == PH_IDLE) && start_i && !reinit_i;
  assign restart = (phase_q == PH_CLISTEN) && (start_i || cmd_i) && !reinit_i;
  assign run     = (phase_q != PH_IDLE) && (phase_q != PH_CLISTEN);

  aow_byte_tick #(.BIT_W(BIT_W), .BITS_PER_BYTE(BITS_PER_BYTE)) u_tick (
    .clk    (clk),
    .rst_n  (rst_n),
    .clear  (accept || restart || reinit_i),
    .run    (run),
    .bit_len(bp_q),
    .tick   (tick)
  );

  aow_len_decode #(.CODE_W(CODE_W), .CNT_W(CNT_W)) u_len (
    .code     (code_q),
    .win_extra(win_extra),
    .is_cont  (is_cont)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      left_q  <= '0;
      code_q  <= '0;
      sel_q   <= '0;
      bp_q    <= BIT_W'(1);
    end else if (reinit_i) begin
      phase_q <= PH_IDLE;
      left_q  <= '0;
    end else if (accept) begin
      phase_q <= PH_LEAD;
      left_q  <= '0;
      code_q  <= code_i;
      sel_q   <= sel_i;
      bp_q    <= (bit_period_i == '0) ? BIT_W'(1) : bit_period_i;
    end else if (restart) begin
      phase_q <= PH_CHOLD;
      left_q  <= CONT_FULL;
    end else if (tick) begin
      if (left_q != '0) begin
        left_q <= left_q - CNT_W'(1);
      end else begin
        case (phase_q)
          PH_LEAD: begin
            if (is_cont) begin
              phase_q <= PH_CHOLD;
              left_q  <= CONT_FIRST;
            end else begin
              phase_q <= PH_WIN;
              left_q  <= win_extra;
            end
          end
          PH_WIN:   phase_q <= PH_TAIL;
          PH_TAIL:  phase_q <= PH_IDLE;
          PH_CHOLD: phase_q <= PH_CLISTEN;
          default:  phase_q <= PH_IDLE;
        endcase
      end
    end
  end

  assign ana_en_o  = (phase_q == PH_WIN) || (phase_q == PH_CHOLD) || (phase_q == PH_CLISTEN);
  assign holdoff_o = (phase_q == PH_LEAD) || (phase_q == PH_WIN) ||
                     (phase_q == PH_TAIL) || (phase_q == PH_CHOLD);
  assign sel_o     = sel_q;
endmodule

// File: rtl/aow_window_checker.sv
module aow_window_checker #(
  parameter int SEL_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_i,
  input logic             reinit_i,
  input logic             ana_en_o,
  input logic             holdoff_o,
  input logic [SEL_W-1:0] sel_o
);
  AST_START_RAISES_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !holdoff_o && !reinit_i) |=> holdoff_o); // R2

  AST_ANA_RISES_IN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ana_en_o) |-> holdoff_o); // R2

  AST_TAIL_AFTER_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ana_en_o) && !$past(reinit_i)) |-> holdoff_o); // R4

  AST_CONT_STAYS_ON: assert property (@(posedge clk) disable iff (!rst_n)
    (ana_en_o && !holdoff_o && !reinit_i) |=> ana_en_o); // R6

  AST_REINIT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    reinit_i |=> (!ana_en_o && !holdoff_o)); // R8

  AST_SEL_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (holdoff_o && $past(holdoff_o)) |-> $stable(sel_o)); // R9
endmodule

bind aow_window_timer aow_window_checker #(.SEL_W(SEL_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .start_i  (start_i),
  .reinit_i (reinit_i),
  .ana_en_o (ana_en_o),
  .holdoff_o(holdoff_o),
  .sel_o    (sel_o)
);

// File: tb/sim_aow_window_timer.sv
module sim_aow_window_timer;
  localparam int CONT = 20;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic       rst_n = 1'b0;
  logic       start_i = 1'b0, cmd_i = 1'b0, reinit_i = 1'b0;
  logic [3:0] code_i = '0, sel_i = '0;
  logic [7:0] bit_period_i = 8'd1;
  logic       ana_en_o, holdoff_o;
  logic [3:0] sel_o;

  aow_window_timer #(.CONT_HOLD_BYTES(CONT)) u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .cmd_i(cmd_i),
    .reinit_i(reinit_i), .code_i(code_i), .sel_i(sel_i),
    .bit_period_i(bit_period_i), .ana_en_o(ana_en_o), .sel_o(sel_o),
    .holdoff_o(holdoff_o)
  );

  int    checks = 0, bad = 0;
  string cur_req = "R1";
  bit    done = 0;

  // behavioural model: 0 idle, 1 timed window, 2 continuous
  int       m_mode = 0, m_t = 0, m_B = 8, m_N = 2, m_hlen = 0;
  bit       m_on = 0;
  logic [3:0] m_sel = '0;

  function automatic bit e_hold();
    if (m_mode == 1) return 1'b1;
    if (m_mode == 2) return m_t < m_hlen;
    return 1'b0;
  endfunction

  function automatic bit e_ana();
    if (m_mode == 1) return (m_t >= m_B) && (m_t < m_B + m_N * m_B);
    if (m_mode == 2) return m_on || (m_t >= m_B);
    return 1'b0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_mode = 0; m_t = 0; m_on = 0; m_sel = '0;
    end else if (reinit_i) begin
      m_mode = 0; m_t = 0; m_on = 0;
    end else if (m_mode == 0) begin
      if (start_i) begin
        m_B = 8 * ((bit_period_i == 0) ? 1 : int'(bit_period_i));
        m_sel = sel_i; m_t = 0; m_on = 0;
        if (code_i == 4'hF) begin m_mode = 2; m_hlen = CONT * m_B; end
        else begin m_mode = 1; m_N = (1 << code_i) + 1; end
      end
    end else if (m_mode == 1) begin
      m_t++;
      if (m_t == (m_N + 2) * m_B) m_mode = 0;
    end else begin
      if (!e_hold() && (start_i || cmd_i)) begin
        m_on = 1; m_t = 0; m_hlen = CONT * m_B;
      end else begin
        if (m_t + 1 >= m_B) m_on = 1;
        m_t++;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(ana_en_o === e_ana(), cur_req, "ana_en_o", int'(ana_en_o), int'(e_ana()));
      chk(holdoff_o === e_hold(), cur_req, "holdoff_o", int'(holdoff_o), int'(e_hold()));
      chk(sel_o === m_sel, "R9", "sel_o", int'(sel_o), int'(m_sel));
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic fire_start(input logic [3:0] code, input logic [3:0] sel, input logic [7:0] bp);
    @(negedge clk);
    code_i = code; sel_i = sel; bit_period_i = bp; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic pulse_cmd(input int len);
    @(negedge clk);
    cmd_i = 1'b1;
    repeat (len) @(negedge clk);
    cmd_i = 1'b0;
  endtask

  task automatic pulse_reinit(input bit with_start);
    @(negedge clk);
    reinit_i = 1'b1; start_i = with_start; code_i = 4'd1;
    @(negedge clk);
    reinit_i = 1'b0; start_i = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++; bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    // R1 reset state
    repeat (3) @(negedge clk);
    chk(ana_en_o === 1'b0, "R1", "ana_en_o in reset", int'(ana_en_o), 0);
    chk(holdoff_o === 1'b0, "R1", "holdoff_o in reset", int'(holdoff_o), 0);
    chk(sel_o === 4'h0, "R1", "sel_o in reset", int'(sel_o), 0);
    rst_n = 1'b1;
    idle(4);

    cur_req = "R2"; fire_start(4'd0, 4'h3, 8'd1);  idle(40);   // R3 code 0
    cur_req = "R3"; fire_start(4'd3, 4'h5, 8'd3);  idle(280);
    cur_req = "R10"; fire_start(4'd5, 4'h9, 8'd0); idle(300);  // bit period 0

    // R5 strobes ignored during hold-off, cmd ignored when idle; R10 inputs change mid-run
    cur_req = "R5";
    pulse_cmd(3); idle(2);
    fire_start(4'd2, 4'hA, 8'd2);
    idle(5); bit_period_i = 8'd7; code_i = 4'd9;
    fire_start(4'd1, 4'h2, 8'd4);
    idle(30); pulse_cmd(2);
    idle(80);

    cur_req = "R4"; fire_start(4'd14, 4'hC, 8'd1); idle(131150); // R3 longest code

    // R6 continuous mode, R7 restarts
    cur_req = "R6"; fire_start(4'hF, 4'h6, 8'd1); idle(200);
    cur_req = "R7";
    pulse_cmd(1); idle(170);
    fire_start(4'd0, 4'hB, 8'd2); idle(10);
    pulse_cmd(160);                       // held across the hold-off expiry
    idle(200);

    // R8 re-initialize
    cur_req = "R8";
    pulse_reinit(1'b0); idle(5);
    fire_start(4'd4, 4'h7, 8'd1); idle(50);
    pulse_reinit(1'b1); idle(10);          // start in same cycle dropped
    fire_start(4'd0, 4'h1, 8'd1); idle(6);
    pulse_reinit(1'b0); idle(40);
    finish_run();
  end
endmodule